// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns a stereo serial audio stream into parallel samples. It takes three wires: a bit clock, a frame clock that separates the left half-frame from the right one, and a serial data line. For each complete frame it presents one left sample and one right sample, both 24 bits wide, and raises a strobe for one cycle. A 2-bit select input picks the framing mode. Two modes place the word at the end of each half-frame (16 or 24 bits). One mode places a 24-bit word at the start. The fourth is the I2S layout, where the word starts one bit after the frame-clock edge.

By default the serial clocks are resynchronised into a faster system clock and the rising edges of the bit clock are detected there. When the `BIT_CLK_DIRECT` parameter is set, the block's clock input is the bit clock itself and every clock edge is one bit slot. The receiver counts the slots in each half-frame. It keeps both the first bits and the most recent bits of the half, so that any of the four placements can be picked out once the half-frame ends.

Top module: `serial_audio_rx`

## Requirements
- R1: While `rst` is high, and in the first cycle after it is released, `valid_o` is 0 and both `left_o` and `right_o` are zero.
- R2: With `fmt` = 2'b00, each half-frame carries a 16-bit word whose LSB is in the half's last bit slot. Slots before it are ignored. The left word is sent while the frame clock is high. The word appears on the output as `{word, 8'h00}`. This holds for 16 and for 32 slots per half-frame.
- R3: With `fmt` = 2'b01, each half-frame carries a 24-bit word whose LSB is in the last slot. Earlier slots are ignored, and the left word is sent while the frame clock is high.
- R4: With `fmt` = 2'b10, the MSB of a 24-bit word is in the first slot after the frame-clock edge. Slots after the LSB are ignored, and the left word is sent while the frame clock is high.
- R5: With `fmt` = 2'b11 and at least 24 slots per half-frame, the MSB of a 24-bit word is one slot after the frame-clock edge. The left word is sent while the frame clock is low.
- R6: With `fmt` = 2'b11 and exactly 16 slots per half-frame, the word is 16 bits and starts one slot after the edge. Its LSB therefore falls in the first slot of the next half-frame. The output is `{word, 8'h00}`.
- R7: Data is taken MSB first, as two's complement, at the rising edge of the bit clock. A data-line change while the bit clock is high has no effect.
- R8: `valid_o` is a one-cycle pulse, raised once the right word of a frame is complete. It is raised only if the left word of the same frame was also received. Between pulses, `left_o` and `right_o` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, or the bit clock when `BIT_CLK_DIRECT` = 1 |
| rst | input | 1 | Synchronous active-high reset |
| bclk | input | 1 | Serial bit clock |
| lrclk | input | 1 | Frame clock that selects left or right |
| sdata | input | 1 | Serial data line |
| fmt | input | 2 | Framing mode select, held stable while receiving |
| left_o | output | 24 | Left sample of the last complete frame |
| right_o | output | 24 | Right sample of the last complete frame |
| valid_o | output | 1 | One-cycle strobe for a new sample pair |

## Verification
Each mode is run at two half-frame lengths. A word that sits correctly at 24 slots could still sit in the wrong place at 32, so the second length shows whether the word position is computed from the actual slot count. Filler slots carry an alternating pattern that no test word matches, and the data line is flipped while the bit clock is high. A receiver that reads the wrong slots, or samples on the wrong edge, therefore returns a visibly different word. The test words include a large negative value and a near-maximum positive value, which expose bit-order swaps and sign errors. The two I2S lengths show whether the block picks 16- or 24-bit words from the slot count.

// File: rtl/sarx_pkg.sv
package sarx_pkg;
  typedef enum logic [1:0] {
    FMT_LSB16 = 2'b00,
    FMT_LSB24 = 2'b01,
    FMT_MSB24 = 2'b10,
    FMT_I2S   = 2'b11
  } fmt_e;
endpackage

// File: rtl/sarx_bit_sampler.sv
module sarx_bit_sampler #(
  parameter int SYNC_STAGES    = 2,
  parameter bit BIT_CLK_DIRECT = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic bclk,
  input  logic lrclk,
  input  logic sdata,
  output logic bit_stb,
  output logic lr_bit,
  output logic sd_bit
);
  generate
    if (BIT_CLK_DIRECT) begin : g_direct
      assign bit_stb = 1'b1;
      assign lr_bit  = lrclk;
      assign sd_bit  = sdata;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] bclk_sync, lr_sync, sd_sync;
      logic                   bclk_last;
      always_ff @(posedge clk) begin
        if (rst) begin
          bclk_sync <= '0;
          lr_sync   <= '0;
          sd_sync   <= '0;
          bclk_last <= 1'b0;
        end else begin
          bclk_sync <= {bclk_sync[SYNC_STAGES-2:0], bclk};
          lr_sync   <= {lr_sync[SYNC_STAGES-2:0], lrclk};
          sd_sync   <= {sd_sync[SYNC_STAGES-2:0], sdata};
          bclk_last <= bclk_sync[SYNC_STAGES-1];
        end
      end
      assign bit_stb = bclk_sync[SYNC_STAGES-1] & ~bclk_last;
      assign lr_bit  = lr_sync[SYNC_STAGES-1];
      assign sd_bit  = sd_sync[SYNC_STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/sarx_slot_tracker.sv
module sarx_slot_tracker
  import sarx_pkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int MAX_SLOTS = 255,
  localparam int CNT_W    = $clog2(MAX_SLOTS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bit_stb,
  input  logic                lr_bit,
  input  logic                sd_bit,
  input  fmt_e                fmt,
  output logic                run_end,
  output logic                run_left,
  output logic [SAMPLE_W-1:0] head,
  output logic [SAMPLE_W-1:0] tail,
  output logic [CNT_W-1:0]    run_len
);
  logic       lr_d, lr_last, run_ok;
  logic [1:0] warm;
  logic       is_i2s, lr_eff, boundary;

  // the one-slot-delayed layout is tracked on a delayed frame clock
  assign is_i2s   = (fmt == FMT_I2S);
  assign lr_eff   = is_i2s ? lr_d : lr_bit;
  assign boundary = (warm == 2'd2) && (lr_eff != lr_last);
  assign run_end  = bit_stb && boundary && run_ok;
  assign run_left = is_i2s ? ~lr_last : lr_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      lr_d    <= 1'b0;
      lr_last <= 1'b0;
      run_ok  <= 1'b0;
      warm    <= 2'd0;
      head    <= '0;
      tail    <= '0;
      run_len <= '0;
    end else if (bit_stb) begin
      lr_d    <= lr_bit;
      lr_last <= lr_eff;
      if (warm != 2'd2) warm <= warm + 2'd1;
      if (boundary) run_ok <= 1'b1;
      tail <= {tail[SAMPLE_W-2:0], sd_bit};
      if (boundary) begin
        head    <= {{(SAMPLE_W-1){1'b0}}, sd_bit};
        run_len <= CNT_W'(1);
      end else begin
        if (run_len < CNT_W'(SAMPLE_W)) head <= {head[SAMPLE_W-2:0], sd_bit};
        if (run_len != CNT_W'(MAX_SLOTS)) run_len <= run_len + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/sarx_word_align.sv
module sarx_word_align
  import sarx_pkg::*;
#(
  parameter int SAMPLE_W  = 24,
  parameter int SHORT_W   = 16,
  parameter int MAX_SLOTS = 255,
  localparam int CNT_W    = $clog2(MAX_SLOTS + 1),
  localparam int PAD_W    = SAMPLE_W - SHORT_W
) (
  input  fmt_e                fmt,
  input  logic [SAMPLE_W-1:0] head,
  input  logic [SAMPLE_W-1:0] tail,
  input  logic [CNT_W-1:0]    run_len,
  output logic [SAMPLE_W-1:0] word
);
  always_comb begin
    case (fmt)
      FMT_LSB16: word = {tail[SHORT_W-1:0], {PAD_W{1'b0}}};
      FMT_LSB24: word = tail;
      FMT_MSB24: word = head;
      default:   word = (run_len >= CNT_W'(SAMPLE_W)) ? head
                                                       : {head[SHORT_W-1:0], {PAD_W{1'b0}}};
    endcase
  end
endmodule

// File: rtl/serial_audio_rx.sv
module serial_audio_rx
  import sarx_pkg::*;
#(
  parameter int SAMPLE_W       = 24,
  parameter int SHORT_W        = 16,
  parameter int MAX_SLOTS      = 255,
  parameter int SYNC_STAGES    = 2,
  parameter bit BIT_CLK_DIRECT = 1'b0,
  localparam int CNT_W         = $clog2(MAX_SLOTS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bclk,
  input  logic                lrclk,
  input  logic                sdata,
  input  logic [1:0]          fmt,
  output logic [SAMPLE_W-1:0] left_o,
  output logic [SAMPLE_W-1:0] right_o,
  output logic                valid_o
);
  fmt_e                mode;
  logic                bit_stb, lr_bit, sd_bit;
  logic                run_end, run_left;
  logic [SAMPLE_W-1:0] head, tail, word, hold_l;
  logic [CNT_W-1:0]    run_len;
  logic                left_pending;

  assign mode = fmt_e'(fmt);

  sarx_bit_sampler #(.SYNC_STAGES(SYNC_STAGES), .BIT_CLK_DIRECT(BIT_CLK_DIRECT)) u_sampler (
    .clk(clk), .rst(rst), .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
    .bit_stb(bit_stb), .lr_bit(lr_bit), .sd_bit(sd_bit)
  );

  sarx_slot_tracker #(.SAMPLE_W(SAMPLE_W), .MAX_SLOTS(MAX_SLOTS)) u_tracker (
    .clk(clk), .rst(rst), .bit_stb(bit_stb), .lr_bit(lr_bit), .sd_bit(sd_bit),
    .fmt(mode), .run_end(run_end), .run_left(run_left),
    .head(head), .tail(tail), .run_len(run_len)
  );

  sarx_word_align #(.SAMPLE_W(SAMPLE_W), .SHORT_W(SHORT_W), .MAX_SLOTS(MAX_SLOTS)) u_align (
    .fmt(mode), .head(head), .tail(tail), .run_len(run_len), .word(word)
  );

  // pair the left word with the right word of the same frame
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_l       <= '0;
      left_pending <= 1'b0;
      left_o       <= '0;
      right_o      <= '0;
      valid_o      <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (run_end) begin
        if (run_left) begin
          hold_l       <= word;
          left_pending <= 1'b1;
        end else if (left_pending) begin
          left_o       <= hold_l;
          right_o      <= word;
          valid_o      <= 1'b1;
          left_pending <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/sarx_chk.sv
module sarx_chk #(
  parameter int SAMPLE_W = 24,
  parameter int SHORT_W  = 16
) (
  input logic                clk,
  input logic                rst,
  input logic [1:0]          fmt,
  input logic                run_end,
  input logic                run_left,
  input logic [SAMPLE_W-1:0] left_o,
  input logic [SAMPLE_W-1:0] right_o,
  input logic                valid_o
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!valid_o && left_o == '0 && right_o == '0));
  // R8
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o);
  // R8
  valid_after_right_chk: assert property (@(posedge clk) disable iff (rst)
    valid_o |-> $past(run_end && !run_left));
  // R8
  hold_between_chk: assert property (@(posedge clk) disable iff (rst)
    !valid_o |-> ($stable(left_o) && $stable(right_o)));
  // R2
  short_pad_chk: assert property (@(posedge clk) disable iff (rst)
    (valid_o && fmt == 2'b00) |->
      (left_o[SAMPLE_W-SHORT_W-1:0] == '0 && right_o[SAMPLE_W-SHORT_W-1:0] == '0));
endmodule

bind serial_audio_rx sarx_chk #(.SAMPLE_W(SAMPLE_W), .SHORT_W(SHORT_W)) u_chk (
  .clk(clk), .rst(rst), .fmt(fmt), .run_end(run_end), .run_left(run_left),
  .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
);

// File: tb/serial_audio_rx_bench.sv
module serial_audio_rx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bclk = 1'b0, lrclk = 1'b0, sdata = 1'b0;
  logic [1:0]  fmt = 2'b00;
  logic [23:0] left_o, right_o;
  logic        valid_o;

  int vecs = 0, fails = 0;
  int cap_n = 0, wide = 0;
  logic [23:0] cap_l [4];
  logic [23:0] cap_r [4];
  logic        prev_valid = 1'b0;
  int          cur_n = 16;
  logic        carry = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_audio_rx u_serial_audio_rx (
    .clk(clk), .rst(rst), .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
    .fmt(fmt), .left_o(left_o), .right_o(right_o), .valid_o(valid_o)
  );

  always @(negedge clk) begin
    if (!rst && valid_o) begin
      if (cap_n < 4) begin
        cap_l[cap_n] = left_o;
        cap_r[cap_n] = right_o;
      end
      cap_n = cap_n + 1;
      if (prev_valid) wide = wide + 1;
    end
    prev_valid = valid_o;
  end

  task automatic chk(input string tag, input logic [23:0] act, input logic [23:0] exp);
    vecs++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int word_bits();
    if (fmt == 2'b00) return 16;
    if (fmt == 2'b11) return (cur_n >= 24) ? 24 : 16;
    return 24;
  endfunction

  function automatic logic lbit(input int i, input logic [23:0] w);
    int wb = word_bits();
    int off = cur_n - wb;
    if (fmt == 2'b00 || fmt == 2'b01) return (i < off) ? logic'(i % 2) : w[23-(i-off)];
    return (i < wb) ? w[23-i] : logic'(i % 2);
  endfunction

  function automatic logic [23:0] expect_word(input logic [23:0] w);
    return (word_bits() == 16) ? {w[23:8], 8'h00} : w;
  endfunction

  task automatic bit_out(input logic lrv, input logic b);
    @(negedge clk);
    lrclk = lrv;
    sdata = b;
    repeat (HALF) @(negedge clk);
    bclk = 1'b1;
    repeat (2) @(negedge clk);
    sdata = ~b;  // change while the bit clock is high: must be ignored (R7)
    repeat (HALF-2) @(negedge clk);
    bclk = 1'b0;
  endtask

  task automatic send_half(input logic lrv, input logic [23:0] w);
    for (int i = 0; i < cur_n; i++) begin
      if (fmt == 2'b11) bit_out(lrv, (i == 0) ? carry : lbit(i-1, w));
      else              bit_out(lrv, lbit(i, w));
    end
    carry = lbit(cur_n-1, w);
  endtask

  task automatic send_frame(input logic [23:0] l, input logic [23:0] r);
    logic lv = (fmt == 2'b11) ? 1'b0 : 1'b1;
    send_half(lv, l);
    send_half(~lv, r);
  endtask

  task automatic run_case(input string tag, input logic [1:0] f, input int n,
                          input logic [23:0] l1, input logic [23:0] r1,
                          input logic [23:0] l2, input logic [23:0] r2);
    @(negedge clk);
    rst = 1'b1; bclk = 1'b0; sdata = 1'b0; carry = 1'b0;
    fmt = f; cur_n = n;
    lrclk = (f == 2'b11) ? 1'b1 : 1'b0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    cap_n = 0;
    send_frame(24'h5A3C96, 24'hC3A569);
    send_frame(l1, r1);
    send_frame(l2, r2);
    send_frame(24'h000000, 24'h000000);
    repeat (10) @(negedge clk);
    chk({tag, " pair count"}, 24'(cap_n), 24'd2);
    chk({tag, " frame1 left"}, cap_l[0], expect_word(l1));
    chk({tag, " frame1 right"}, cap_r[0], expect_word(r1));
    chk({tag, " frame2 left"}, cap_l[1], expect_word(l2));
    chk({tag, " frame2 right"}, cap_r[1], expect_word(r2));
    chk({tag, " R8 held left"}, left_o, expect_word(l2));
    chk({tag, " R8 held right"}, right_o, expect_word(r2));
  endtask

  task automatic test_reset();
    rst = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 valid in reset", 24'(valid_o), 24'd0);
    chk("R1 left in reset", left_o, 24'h0);
    chk("R1 right in reset", right_o, 24'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 valid after release", 24'(valid_o), 24'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    test_reset();
    run_case("R2 n16", 2'b00, 16, 24'h812300, 24'h7FFE00, 24'h1234AB, 24'hFEDCBA);
    run_case("R2 n32", 2'b00, 32, 24'hA5C300, 24'h3C5A00, 24'h800100, 24'h00FF00);
    run_case("R3 n24", 2'b01, 24, 24'h800001, 24'h7FFFFE, 24'h13579B, 24'hECA864);
    run_case("R3 n32", 2'b01, 32, 24'h2468AC, 24'hF0E1D2, 24'h800001, 24'h0F1E2D);
    run_case("R4 R7 n32", 2'b10, 32, 24'h800001, 24'h7FFFFE, 24'hABCDEF, 24'h0C0FFE);
    run_case("R4 n24", 2'b10, 24, 24'h96C3A5, 24'h1B2D3C, 24'hFFFFFE, 24'h000002);
    run_case("R5 n32", 2'b11, 32, 24'h800001, 24'h7FFFFE, 24'hDEAD01, 24'h01BEEF);
    run_case("R6 n16", 2'b11, 16, 24'h8001AA, 24'h7FFE55, 24'hC3C3FF, 24'h3C3C11);
    chk("R8 valid pulse width", 24'(wide), 24'd0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule